// File: doc/BRIEF.md
# Show Cycle and External Bus Arbitration Controller

This block sits between an on-chip module bus and the external bus pins. Each internal transfer is announced by a one-cycle strobe that carries an address, data and a direction. Depending on a two-bit policy field, the block can copy each such transfer onto the external pins for one cycle as a "show cycle", so a logic analyser or an emulator can watch internal traffic. The same field decides whether an external master that raises a bus request can get a bus grant.

The policy has four values. It can turn show cycles off and allow arbitration. It can turn show cycles on and forbid arbitration. It can allow both. Or it can allow both and freeze internal activity for as long as the external master holds the bus. A grant is only issued between transfers and is held until the request is withdrawn. The policy field is written through a strobe. A write that arrives while a grant or a show cycle is active is held back and applied once the bus goes quiet.

Top module: `showarb_ctrl`

## Requirements
- R1: After reset, `mode_active` is 00, and `ext_bg`, `ext_show` and `int_stall` are all low.
- R2: With mode 00, an internal transfer never raises `ext_show`. An external request raised between transfers is granted: `ext_bg` rises one cycle after the request is first sampled.
- R3: With mode 01, 10 or 11 and no grant active, a transfer strobed in cycle t makes `ext_show` high in cycle t+1 only. In that cycle `ext_addr`, `ext_data` and `ext_rw` carry that transfer's address, data and direction (1 = write).
- R4: With mode 01, `ext_bg` never rises, however long `ext_br` is held high.
- R5: With mode 10, transfers made while the bus is granted give no show cycle, and `int_stall` stays low.
- R6: With mode 11, `int_stall` is high exactly while `ext_bg` is high. A transfer attempted during that time is not shown. Both outputs fall one cycle after `ext_br` falls.
- R7: A grant is decided only in a cycle with no internal strobe and no show cycle on the pins. A request that arrives during a transfer is granted one cycle after the first quiet cycle.
- R8: Once granted, `ext_bg` stays high while `ext_br` is high. It falls in the cycle after `ext_br` is seen low.
- R9: The `mode_wr`/`mode_in` write appears on `mode_active` (00, 01, 10, 11 as above) in the next cycle when the bus is quiet. If a grant or a show cycle is active, the write waits and is applied one cycle after the first quiet cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_strobe | input | 1 | One-cycle strobe marking an internal transfer |
| int_addr | input | AW | Internal transfer address |
| int_data | input | DW | Internal transfer data |
| int_write | input | 1 | Internal transfer direction, 1 = write |
| ext_br | input | 1 | External master bus request |
| mode_wr | input | 1 | Write strobe for the policy field |
| mode_in | input | 2 | New policy value |
| ext_addr | output | AW | Address shown on the pins during a show cycle |
| ext_data | output | DW | Data shown on the pins during a show cycle |
| ext_rw | output | 1 | Direction shown during a show cycle |
| ext_show | output | 1 | Show strobe; address and data are driven while high |
| ext_bg | output | 1 | Bus grant to the external master |
| int_stall | output | 1 | Halts internal bus activity |
| mode_active | output | 2 | Policy currently in force |

## Verification
The bench aims at the corner cases where the controller's timing is easiest to get wrong.

- **Request during a transfer.** A request raised in the same cycle as a transfer must wait until both the strobe and the show cycle that follows it have passed. A design that checks only the strobe would grant one cycle early, while the pins still carry show data.
- **Policy write during activity.** A policy write lands once during a show cycle and once during a grant. A design that applies it at once would change the policy in the middle of an activity, and one that drops it would never reach the new policy.
- **Transfers while granted.** Transfers are issued while the bus is granted in both granting show modes. A design that still mirrors them would drive the pins against the other master, and one that mixes up the two modes would stall or fail to stall.

// File: rtl/showarb_pkg.sv
package showarb_pkg;
  typedef enum logic [1:0] {
    POL_QUIET   = 2'b00,
    POL_EXCL    = 2'b01,
    POL_SHARE   = 2'b10,
    POL_FREEZE  = 2'b11
  } show_pol_e;
endpackage

// File: rtl/showarb_policy.sv
module showarb_policy
  import showarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [1:0] wr_val,
  input  logic      quiet,
  output show_pol_e pol
);
  show_pol_e pol_q, pol_d;
  logic      pend_q, pend_d;
  logic [1:0] pval_q, pval_d;
  logic      have_cand;
  logic [1:0] cand;

  always_comb begin
    have_cand = wr | pend_q;
    cand      = wr ? wr_val : pval_q;
    pol_d     = pol_q;
    pend_d    = pend_q;
    pval_d    = pval_q;
    if (have_cand && quiet) begin
      pol_d  = show_pol_e'(cand);
      pend_d = 1'b0;
    end else if (have_cand) begin
      pend_d = 1'b1;
      pval_d = cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= POL_QUIET;
      pend_q <= 1'b0;
      pval_q <= 2'b00;
    end else if (have_cand) begin
      pol_q  <= pol_d;
      pend_q <= pend_d;
      pval_q <= pval_d;
    end
  end

  assign pol = pol_q;

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> $stable(pol_q));
endmodule

// File: rtl/showarb_grant.sv
module showarb_grant
  import showarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  show_pol_e pol,
  input  logic      boundary,
  output logic      bg,
  output logic      grant_set,
  output logic      stall
);
  logic bg_q, bg_d, grant_clr, arb_ok;

  always_comb begin
    arb_ok    = (pol != POL_EXCL);
    grant_set = !bg_q && req && arb_ok && boundary;
    grant_clr = bg_q && !req;
    bg_d      = bg_q;
    if (grant_set)      bg_d = 1'b1;
    else if (grant_clr) bg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     bg_q <= 1'b0;
    else if (grant_set || grant_clr) bg_q <= bg_d;
  end

  assign bg    = bg_q;
  assign stall = bg_q && (pol == POL_FREEZE);

  assert_no_grant_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_EXCL) |-> !bg_q);
  assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_q && req) |=> bg_q);
  assert_grant_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_q && !boundary) |=> !bg_q);
endmodule

// File: rtl/showarb_mirror.sv
module showarb_mirror #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          write,
  input  logic          show_en,
  output logic          show,
  output logic [AW-1:0] x_addr,
  output logic [DW-1:0] x_data,
  output logic          x_rw
);
  logic          show_q, show_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rw_q;

  always_comb show_d = strobe && show_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) show_q <= 1'b0;
    else        show_q <= show_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rw_q   <= 1'b0;
    end else if (show_d) begin
      addr_q <= addr;
      data_q <= data;
      rw_q   <= write;
    end
  end

  assign show   = show_q;
  assign x_addr = addr_q;
  assign x_data = data_q;
  assign x_rw   = rw_q;
endmodule

// File: rtl/showarb_ctrl.sv
module showarb_ctrl
  import showarb_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_strobe,
  input  logic [AW-1:0] int_addr,
  input  logic [DW-1:0] int_data,
  input  logic          int_write,
  input  logic          ext_br,
  input  logic          mode_wr,
  input  logic [1:0]    mode_in,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_data,
  output logic          ext_rw,
  output logic          ext_show,
  output logic          ext_bg,
  output logic          int_stall,
  output logic [1:0]    mode_active
);
  show_pol_e pol;
  logic      bg, grant_set, stall, show, boundary, quiet, show_en;

  assign boundary = !int_strobe && !show;
  assign quiet    = !bg && !show && !grant_set;
  assign show_en  = (pol != POL_QUIET) && !bg;

  showarb_policy u_policy (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wr_val(mode_in),
    .quiet(quiet), .pol(pol)
  );

  showarb_grant u_grant (
    .clk(clk), .rst_n(rst_n), .req(ext_br), .pol(pol), .boundary(boundary),
    .bg(bg), .grant_set(grant_set), .stall(stall)
  );

  showarb_mirror #(.AW(AW), .DW(DW)) u_mirror (
    .clk(clk), .rst_n(rst_n), .strobe(int_strobe), .addr(int_addr),
    .data(int_data), .write(int_write), .show_en(show_en), .show(show),
    .x_addr(ext_addr), .x_data(ext_data), .x_rw(ext_rw)
  );

  assign ext_show    = show;
  assign ext_bg      = bg;
  assign int_stall   = stall;
  assign mode_active = pol;

  assert_no_show_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(show && bg));
  assert_stall_only_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (bg && mode_active == 2'b11));
  assert_quiet_no_show_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active == 2'b00) |=> !ext_show);
endmodule

// File: tb/showarb_ctrl_tb_top.sv
module showarb_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int K_SHOW = 0, K_ADDR = 1, K_DATA = 2, K_RW = 3,
                 K_BG = 4, K_STALL = 5, K_MODE = 6;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] val;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_strobe = 1'b0, int_write = 1'b0, ext_br = 1'b0, mode_wr = 1'b0;
  logic [AW-1:0] int_addr = '0;
  logic [DW-1:0] int_data = '0;
  logic [1:0] mode_in = 2'b00;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_data;
  logic ext_rw, ext_show, ext_bg, int_stall;
  logic [1:0] mode_active;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  showarb_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .int_strobe(int_strobe), .int_addr(int_addr),
    .int_data(int_data), .int_write(int_write), .ext_br(ext_br),
    .mode_wr(mode_wr), .mode_in(mode_in), .ext_addr(ext_addr),
    .ext_data(ext_data), .ext_rw(ext_rw), .ext_show(ext_show),
    .ext_bg(ext_bg), .int_stall(int_stall), .mode_active(mode_active)
  );

  function automatic logic [31:0] actual(int k);
    case (k)
      K_SHOW:  return {31'd0, ext_show};
      K_ADDR:  return {8'd0, ext_addr};
      K_DATA:  return {16'd0, ext_data};
      K_RW:    return {31'd0, ext_rw};
      K_BG:    return {31'd0, ext_bg};
      K_STALL: return {31'd0, int_stall};
      default: return {30'd0, mode_active};
    endcase
  endfunction

  // driver side: queue an expected value d cycles ahead, kept sorted by cycle
  task automatic exp(int d, int k, logic [31:0] v, string r);
    item_t it;
    int pos;
    it.cyc = cyc + d; it.kind = k; it.val = v; it.req = r;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > it.cyc) begin pos = i; break; end
    end
    q.insert(pos, it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      a = actual(it.kind);
      checks++;
      if (it.cyc != cyc || a !== it.val) begin
        fails++;
        $display("FAIL %s kind %0d cyc %0d: got %0h expected %0h",
                 it.req, it.kind, it.cyc, a, it.val);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    exp(1, K_MODE, 0, "R1"); exp(1, K_BG, 0, "R1");
    exp(1, K_SHOW, 0, "R1"); exp(1, K_STALL, 0, "R1");
    tick();
    // R2 mode 00: no show, grant allowed
    int_strobe = 1; int_addr = 24'h00A5A5; int_data = 16'h1111; int_write = 1;
    exp(1, K_SHOW, 0, "R2");
    tick();
    int_strobe = 0; ext_br = 1;
    exp(1, K_BG, 1, "R2");
    tick();
    exp(1, K_BG, 1, "R8");
    tick();
    ext_br = 0;
    exp(1, K_BG, 0, "R8");
    tick();
    // R9 immediate write to 01
    mode_wr = 1; mode_in = 2'b01;
    exp(1, K_MODE, 1, "R9");
    tick();
    mode_wr = 0;
    // R3 show in mode 01
    int_strobe = 1; int_addr = 24'h123456; int_data = 16'hBEEF; int_write = 1;
    exp(1, K_SHOW, 1, "R3"); exp(1, K_ADDR, 32'h123456, "R3");
    exp(1, K_DATA, 32'hBEEF, "R3"); exp(1, K_RW, 1, "R3");
    exp(2, K_SHOW, 0, "R3");
    tick();
    int_strobe = 0;
    tick();
    // R4 no grant in mode 01
    ext_br = 1;
    for (int i = 1; i <= 5; i++) exp(i, K_BG, 0, "R4");
    repeat (5) tick();
    ext_br = 0;
    tick();
    // R9 write during a show cycle waits
    int_strobe = 1; int_addr = 24'h000777; int_data = 16'h2222; int_write = 0;
    exp(1, K_SHOW, 1, "R3"); exp(1, K_RW, 0, "R3");
    tick();
    int_strobe = 0; mode_wr = 1; mode_in = 2'b10;
    exp(1, K_MODE, 1, "R9"); exp(2, K_MODE, 2, "R9");
    tick();
    mode_wr = 0;
    tick();
    // R7 request during a transfer waits for a quiet cycle
    int_strobe = 1; int_addr = 24'h0000F0; int_data = 16'h3333; int_write = 1;
    ext_br = 1;
    exp(1, K_SHOW, 1, "R3"); exp(1, K_BG, 0, "R7");
    exp(2, K_BG, 0, "R7"); exp(3, K_BG, 1, "R7");
    tick();
    int_strobe = 0;
    tick();
    tick();
    // R5 mode 10 granted: no show, no stall; R9 write during grant waits
    int_strobe = 1; int_addr = 24'h000ABC; int_data = 16'h4444;
    mode_wr = 1; mode_in = 2'b11;
    exp(1, K_SHOW, 0, "R5"); exp(1, K_STALL, 0, "R5");
    exp(1, K_BG, 1, "R5"); exp(1, K_MODE, 2, "R9");
    tick();
    int_strobe = 0; mode_wr = 0; ext_br = 0;
    exp(1, K_BG, 0, "R8"); exp(1, K_MODE, 2, "R9"); exp(2, K_MODE, 3, "R9");
    tick();
    tick();
    // R6 mode 11 stall follows grant
    ext_br = 1;
    exp(1, K_BG, 1, "R6"); exp(1, K_STALL, 1, "R6");
    tick();
    int_strobe = 1; int_addr = 24'h000DEF; int_data = 16'h5555;
    exp(1, K_SHOW, 0, "R6"); exp(1, K_STALL, 1, "R6");
    tick();
    int_strobe = 0; ext_br = 0;
    exp(1, K_STALL, 0, "R6"); exp(1, K_BG, 0, "R6");
    tick();
    // R3 show in mode 11 without grant
    int_strobe = 1; int_addr = 24'h00CAFE; int_data = 16'h6666; int_write = 0;
    exp(1, K_SHOW, 1, "R3"); exp(1, K_ADDR, 32'h00CAFE, "R3");
    exp(1, K_DATA, 32'h6666, "R3"); exp(1, K_RW, 0, "R3");
    tick();
    int_strobe = 0;
    repeat (4) tick();
    if (q.size() != 0) begin
      fails++; checks++;
      $display("FAIL drain: got %0d pending expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule